// File: doc/BRIEF.md
# Predicated Branch and Return-Stack Unit

This unit works out the next program counter of a small stack processor when it executes jumps, calls and returns. The program counter is not a separate register. It is the entry on top of a 16-deep, 10-bit return stack. A call advances the stack pointer into a fresh slot that holds the destination, so the caller's incremented address stays saved in the slot underneath. A return steps the pointer back down. A taken jump overwrites the top entry in place.

Each accepted operation runs through a three-state sequence. In `ST_IDLE` the unit waits. The transition `IDLE->BUMP` is taken when `adv_i` is high, and at that edge the unit latches the operation kind, the DROP bit, the destination and the predicate result on the current top of data stack. In `ST_BUMP` the top entry is written back incremented by one, which models the fetch. The transition `BUMP->XFER` is unconditional. In `ST_XFER` the control transfer is applied and the one-cycle `taken_o` and `pop_o` pulses are driven. The transition `XFER->IDLE` is also unconditional. The data-stack pop itself is carried out by the data-stack logic outside this unit, which acts on `pop_o`.

Top module: `brs_branch_unit`

## Requirements
- R1: After reset, `pc_o` equals `RESET_PC` (default 0), `err_o`, `taken_o` and `pop_o` are 0, and the stack pointer is at slot 0.
- R2: The predicate is `ins_i[13:11]` and is evaluated on `st0_i`, read as signed two's complement and sampled in the cycle that `adv_i` is accepted. Code 0 is never taken, 1 is ST0<0, 2 is ST0==0, 3 is ST0<=0, 4 is ST0>0, 5 is ST0!=0, 6 is ST0>=0 and 7 is always taken. A change on `st0_i` after acceptance has no effect.
- R3: `pop_o` pulses for a jump or call whose DROP bit `ins_i[10]` is 1, whether or not the branch is taken. It never pulses for a step or a return.
- R4: Every accepted operation first increments the top entry by one. An operation of kind step (`op_i`=00) therefore moves `pc_o` to the old value plus one.
- R5: A taken jump (`op_i`=10) sets `pc_o` to `ins_i[9:0]` without changing the stack depth. A jump or call that is not taken leaves `pc_o` at the old value plus one.
- R6: A taken call (`op_i`=11) sets `pc_o` to `ins_i[9:0]` and saves the old value plus one in the slot below.
- R7: A return (`op_i`=01) is unconditional and makes the saved entry below the current one the new `pc_o`.
- R8: A taken call at slot 15 or a return at slot 0 sets `err_o`, and the pointer wraps modulo 16. `err_o` stays set until reset.
- R9: `adv_i` is ignored outside `ST_IDLE`, and `pc_o` is stable while the unit is idle with `adv_i` low.
- R10: Timing: `taken_o` and `pop_o` are one-cycle pulses on the second edge after acceptance, and `pc_o` shows the result after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance strobe that starts one operation |
| op_i | input | 2 | Kind: 00 step, 01 return, 10 jump, 11 call |
| ins_i | input | 14 | Predicate [13:11], DROP [10], destination [9:0] |
| st0_i | input | 16 | Top of data stack |
| pc_o | output | 10 | Current program counter (top of the return stack) |
| taken_o | output | 1 | Jump or call taken (one-cycle pulse) |
| pop_o | output | 1 | Data-stack pop request (one-cycle pulse) |
| err_o | output | 1 | Sticky overflow or underflow flag |

## Verification
The bench sweeps all eight predicate codes against zero, +1, -1, the extreme positive value and the extreme negative value, for both jumps and calls and with DROP both clear and set. This range catches a design that treats ST0 as unsigned, which would make 0x8000 count as positive, and a design that ties the pop to the taken decision, which would lose drops on branches that are not taken. Some operations hold `adv_i` high through `ST_BUMP` and change `st0_i` after acceptance. A design that resampled the strobe would start a second operation, and a design that re-evaluated the predicate would take the wrong branch. The bench also drives the stack to exactly 16 nested calls and performs a return at slot 0. A design that checked the wrong boundary would flag the error one call early or one call late, or would fail to hold the flag once it was set.

// File: rtl/brs_pkg.sv
package brs_pkg;

    localparam int PRED_W = 3;

    typedef enum logic [1:0] {
        OP_STEP = 2'b00,
        OP_RET  = 2'b01,
        OP_JUMP = 2'b10,
        OP_CALL = 2'b11
    } brs_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUMP = 2'b01,
        ST_XFER = 2'b10
    } brs_state_e;

endpackage

// File: rtl/brs_pred_eval.sv
module brs_pred_eval
    import brs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] st0_i,
    input  logic [PRED_W-1:0] pred_i,
    output logic              hit_o
);
    logic is_neg;
    logic is_zero;
    logic is_pos;

    // Predicate bits select among the three mutually exclusive sign classes.
    always_comb begin
        is_neg  = st0_i[DATA_W-1];
        is_zero = (st0_i == '0);
        is_pos  = !is_neg && !is_zero;
        hit_o   = |(pred_i & {is_pos, is_zero, is_neg});
    end
endmodule

// File: rtl/brs_seq.sv
module brs_seq
    import brs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  brs_op_e           op_i,
    input  logic              hit_i,
    input  logic              drop_i,
    input  logic [ADDR_W-1:0] dest_i,
    output brs_state_e        state_o,
    output brs_op_e           op_o,
    output logic [ADDR_W-1:0] dest_o,
    output logic              bump_o,
    output logic              apply_o,
    output logic              taken_o,
    output logic              pop_o
);
    brs_state_e state_q;
    brs_state_e state_d;
    brs_op_e    op_q;
    logic       hit_q;
    logic       drop_q;
    logic [ADDR_W-1:0] dest_q;
    logic       is_branch;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (adv_i) state_d = ST_BUMP;
            ST_BUMP: state_d = ST_XFER;
            ST_XFER: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Operation latched on acceptance; predicate frozen on the original ST0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_STEP;
            hit_q  <= 1'b0;
            drop_q <= 1'b0;
            dest_q <= '0;
        end else if (state_q == ST_IDLE && adv_i) begin
            op_q   <= op_i;
            hit_q  <= hit_i;
            drop_q <= drop_i;
            dest_q <= dest_i;
        end
    end

    always_comb begin
        is_branch = (op_q == OP_JUMP) || (op_q == OP_CALL);
        bump_o    = (state_q == ST_BUMP);
        apply_o   = (state_q == ST_XFER);
        taken_o   = apply_o && is_branch && hit_q;
        pop_o     = apply_o && is_branch && drop_q;
        state_o   = state_q;
        op_o      = op_q;
        dest_o    = dest_q;
    end
endmodule

// File: rtl/brs_ret_stack.sv
module brs_ret_stack
    import brs_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DEPTH    = 16,
    parameter int RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bump_i,
    input  logic              apply_i,
    input  brs_op_e           op_i,
    input  logic              taken_i,
    input  logic [ADDR_W-1:0] dest_i,
    output logic [ADDR_W-1:0] top_o,
    output logic              err_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_d;
    logic [PTR_W-1:0]  ptr_up;
    logic [PTR_W-1:0]  ptr_dn;
    logic [PTR_W-1:0]  wr_idx;
    logic [ADDR_W-1:0] wr_val;
    logic              wr_act;
    logic              err_set;
    logic              err_q;
    logic [DEPTH-1:0]  wr_en;

    assign top_o  = slot_q[ptr_q];
    assign ptr_up = ptr_q + 1'b1;
    assign ptr_dn = ptr_q - 1'b1;
    assign err_o  = err_q;

    // One write port: fetch bump, in-place jump, or push on call.
    always_comb begin
        wr_act  = 1'b0;
        wr_idx  = ptr_q;
        wr_val  = top_o;
        ptr_d   = ptr_q;
        err_set = 1'b0;
        if (bump_i) begin
            wr_act = 1'b1;
            wr_val = top_o + 1'b1;
        end else if (apply_i && taken_i && op_i == OP_JUMP) begin
            wr_act = 1'b1;
            wr_val = dest_i;
        end else if (apply_i && taken_i && op_i == OP_CALL) begin
            wr_act  = 1'b1;
            wr_idx  = ptr_up;
            wr_val  = dest_i;
            ptr_d   = ptr_up;
            err_set = (ptr_q == PTR_MAX);
        end else if (apply_i && op_i == OP_RET) begin
            ptr_d   = ptr_dn;
            err_set = (ptr_q == '0);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_wen
        assign wr_en[g] = wr_act && (wr_idx == PTR_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                slot_q[i] <= (i == 0) ? ADDR_W'(RESET_PC) : '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if (wr_en[i]) slot_q[i] <= wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            err_q <= 1'b0;
        end else begin
            ptr_q <= ptr_d;
            if (err_set) err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/brs_branch_unit.sv
module brs_branch_unit
    import brs_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 10,
    parameter int DEPTH    = 16,
    parameter int RESET_PC = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv_i,
    input  logic [1:0]               op_i,
    input  logic [PRED_W+ADDR_W:0]   ins_i,
    input  logic [DATA_W-1:0]        st0_i,
    output logic [ADDR_W-1:0]        pc_o,
    output logic                     taken_o,
    output logic                     pop_o,
    output logic                     err_o
);
    localparam int DROP_BIT = ADDR_W;
    localparam int PRED_LO  = ADDR_W + 1;

    logic [PRED_W-1:0] pred_f;
    logic              drop_f;
    logic [ADDR_W-1:0] dest_f;
    logic              hit;
    brs_state_e        state;
    brs_op_e           op_q;
    logic [ADDR_W-1:0] dest_q;
    logic              bump;
    logic              apply;

    assign pred_f = ins_i[PRED_LO +: PRED_W];
    assign drop_f = ins_i[DROP_BIT];
    assign dest_f = ins_i[ADDR_W-1:0];

    brs_pred_eval #(.DATA_W(DATA_W)) pred_i (
        .st0_i  (st0_i),
        .pred_i (pred_f),
        .hit_o  (hit)
    );

    brs_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv_i),
        .op_i    (brs_op_e'(op_i)),
        .hit_i   (hit),
        .drop_i  (drop_f),
        .dest_i  (dest_f),
        .state_o (state),
        .op_o    (op_q),
        .dest_o  (dest_q),
        .bump_o  (bump),
        .apply_o (apply),
        .taken_o (taken_o),
        .pop_o   (pop_o)
    );

    brs_ret_stack #(
        .ADDR_W   (ADDR_W),
        .DEPTH    (DEPTH),
        .RESET_PC (RESET_PC)
    ) stk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump_i  (bump),
        .apply_i (apply),
        .op_i    (op_q),
        .taken_i (taken_o),
        .dest_i  (dest_q),
        .top_o   (pc_o),
        .err_o   (err_o)
    );
endmodule

// File: rtl/brs_branch_chk.sv
module brs_branch_chk
    import brs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic              taken_o,
    input logic              pop_o,
    input logic              err_o,
    input brs_state_e        state,
    input brs_op_e           op_q,
    input logic [ADDR_W-1:0] dest_q
);
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R8

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o || pop_o) |=> !(taken_o || pop_o)); // R10

    AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && op_q == OP_JUMP) |=> (pc_o == $past(dest_q))); // R5

    AST_CALL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && op_q == OP_CALL) |=> (pc_o == $past(dest_q))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !adv_i) |=> $stable(pc_o)); // R9

    AST_POP_BRANCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |-> (op_q == OP_JUMP || op_q == OP_CALL)); // R3

    AST_BUSY_IGNORES_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUMP) |=> (state == ST_XFER)); // R9
endmodule

bind brs_branch_unit brs_branch_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (adv_i),
    .pc_o    (pc_o),
    .taken_o (taken_o),
    .pop_o   (pop_o),
    .err_o   (err_o),
    .state   (state),
    .op_q    (op_q),
    .dest_q  (dest_q)
);

// File: tb/brs_branch_unit_tb_top.sv
`timescale 1ns/1ps
module brs_branch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [13:0] ins_i = '0;
    logic [15:0] st0_i = '0;
    logic [9:0]  pc_o;
    logic        taken_o, pop_o, err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [9:0] m_stk [16];
    logic [3:0] m_ptr;
    logic       m_err;

    always #2 clk = ~clk;

    brs_branch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .op_i(op_i), .ins_i(ins_i),
        .st0_i(st0_i), .pc_o(pc_o), .taken_o(taken_o), .pop_o(pop_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic pred_ref(input logic [2:0] p, input logic [15:0] v);
        int s;
        s = int'($signed(v));
        case (p)
            3'd0: return 1'b0;
            3'd1: return s < 0;
            3'd2: return s == 0;
            3'd3: return s <= 0;
            3'd4: return s > 0;
            3'd5: return s != 0;
            3'd6: return s >= 0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; adv_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) m_stk[i] = '0;
        m_ptr = '0; m_err = 1'b0;
        chk("R1 pc", {6'd0, pc_o}, 16'd0);
        chk("R1 err", {15'd0, err_o}, 16'd0);
        chk("R1 taken/pop", {14'd0, taken_o, pop_o}, 16'd0);
    endtask

    // Starts and ends at a negedge; noisy keeps adv_i high and changes st0_i while busy.
    task automatic do_op(input logic [1:0] op, input logic [2:0] pred, input logic drop,
                         input logic [9:0] dest, input logic [15:0] st0, input bit noisy);
        logic e_take, e_pop;
        e_take = op[1] && pred_ref(pred, st0);
        e_pop  = op[1] && drop;
        m_stk[m_ptr] = m_stk[m_ptr] + 10'd1;
        if (op == 2'b10 && e_take) m_stk[m_ptr] = dest;
        if (op == 2'b11 && e_take) begin
            if (m_ptr == 4'd15) m_err = 1'b1;
            m_ptr = m_ptr + 4'd1;
            m_stk[m_ptr] = dest;
        end
        if (op == 2'b01) begin
            if (m_ptr == 4'd0) m_err = 1'b1;
            m_ptr = m_ptr - 4'd1;
        end
        adv_i = 1'b1; op_i = op; ins_i = {pred, drop, dest}; st0_i = st0;
        @(negedge clk);
        if (noisy) begin
            op_i = 2'b11; ins_i = {3'd7, 1'b1, 10'h3ff}; st0_i = ~st0 + 16'd1;
        end else adv_i = 1'b0;
        @(negedge clk);
        adv_i = 1'b0;
        chk("R2 taken", {15'd0, taken_o}, {15'd0, e_take});
        chk("R3 pop", {15'd0, pop_o}, {15'd0, e_pop});
        @(negedge clk);
        chk("R10 pulse end", {14'd0, taken_o, pop_o}, 16'd0);
        chk("R4/R5/R6/R7 pc", {6'd0, pc_o}, {6'd0, m_stk[m_ptr]});
        chk("R8 err", {15'd0, err_o}, {15'd0, m_err});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] vals [6];
        logic [9:0]  pc0;
        int          k;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hffff;
        vals[3] = 16'h7fff; vals[4] = 16'h8000; vals[5] = 16'h0005;
        do_reset();

        // R9: idle without strobe holds pc
        repeat (3) @(negedge clk);
        chk("R9 idle hold", {6'd0, pc_o}, 16'd0);

        // R4: plain steps
        for (int i = 0; i < 3; i++) do_op(2'b00, 3'd7, 1'b1, 10'h155, 16'h0, 0);
        chk("R3 step no pop result", {6'd0, pc_o}, 16'd3);

        // R2/R3/R5/R6/R7 sweep over kind, predicate, value and DROP
        k = 0;
        for (int o = 2; o < 4; o++)
            for (int p = 0; p < 8; p++)
                for (int v = 0; v < 6; v++)
                    for (int d = 0; d < 2; d++) begin
                        k++;
                        do_op(2'(o), 3'(p), 1'(d), 10'((k * 37 + 5) & 10'h3ff), vals[v], (k % 5) == 0);
                        if (o == 3 && pred_ref(3'(p), vals[v])) begin
                            pc0 = m_stk[m_ptr - 4'd1];
                            do_op(2'b01, 3'd0, 1'b0, 10'h0, 16'h0, 0);
                            chk("R7 return to caller+1", {6'd0, pc_o}, {6'd0, pc0});
                        end
                    end

        // R6/R8: exactly 16 nested calls
        do_reset();
        for (int i = 0; i < 15; i++) do_op(2'b11, 3'd7, 1'b0, 10'(100 + i), 16'h0, 0);
        chk("R8 no error at slot 15", {15'd0, err_o}, 16'd0);
        do_op(2'b11, 3'd7, 1'b0, 10'h2aa, 16'h0, 0);
        chk("R8 overflow", {15'd0, err_o}, 16'd1);
        do_op(2'b01, 3'd0, 1'b0, 10'h0, 16'h0, 0);
        do_op(2'b10, 3'd2, 1'b1, 10'h011, 16'h0, 0);
        chk("R8 sticky", {15'd0, err_o}, 16'd1);

        // R8: underflow then reset clears
        do_reset();
        do_op(2'b01, 3'd0, 1'b0, 10'h0, 16'h0, 0);
        chk("R8 underflow", {15'd0, err_o}, 16'd1);
        do_reset();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule